// File: doc/BRIEF.md
# Voltage Channel Limit Monitor

This block watches nine voltage measurement channels. An upstream converter delivers one 8-bit reading at a time, qualified by a valid strobe and tagged with a channel index. Each reading is 8 mV per count, so full scale is 0 to 2.040 V. Channel 0 carries the device's own 3.3 V supply, halved internally before conversion. The block compares each reading against that channel's programmed low and high limits. A reading outside the window latches the channel's alarm bit.

Limits are held as six-bit quantities, so the two lowest bits always read back as zero and limits move in 32 mV steps. Software programs and reads the limits through a simple address/data port. A read strobe aimed at a dedicated acknowledge address clears the whole alarm bitmask. The bitmask is always visible on its own output.

Top module: `volt_limit_mon`

## Requirements
- R1: While reset is asserted and after it is released, all low limits read 0x00, all high limits read 0xFC, and `alarm_mask` is all zeros.
- R2: A write with `reg_addr` = c (c = 0..8) sets channel c's low limit, and a write with `reg_addr` = 16 + c sets its high limit. `reg_rdata` shows the addressed limit combinationally from the cycle after the write edge. Any other address reads as 0x00, and writes to it change nothing.
- R3: Bits [1:0] of every limit read back as 0 whatever was written. Comparisons use the stored value, bits [7:2] of the write data followed by two zero bits.
- R4: A valid sample strictly below its channel's low limit raises that channel's alarm. A sample equal to the low limit does not.
- R5: A valid sample strictly above its channel's high limit raises that channel's alarm. A sample equal to the high limit does not.
- R6: Bit c of `alarm_mask` belongs to channel c, with 1 meaning alarm. It becomes 1 on the clock edge that accepts the offending sample.
- R7: Alarm bits are sticky. A later in-range sample of the same channel does not clear them.
- R8: A cycle with `reg_re` high and `reg_addr` = 31 clears every alarm bit at that edge. A violating sample accepted in the same cycle still sets its own bit.
- R9: A sample whose channel index is 9 or above has no effect on `alarm_mask`.
- R10: When a limit write and a sample of the same channel share a cycle, the comparison uses the limit value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample valid strobe |
| smp_ch | input | 4 | Channel index of the sample |
| smp_data | input | 8 | Converted reading, 8 mV per count |
| reg_we | input | 1 | Limit write strobe |
| reg_re | input | 1 | Read strobe; at address 31 it acknowledges and clears alarms |
| reg_addr | input | 5 | Register address: 0..8 low limits, 16..24 high limits, 31 acknowledge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read-back of the addressed limit |
| alarm_mask | output | 9 | Sticky per-channel alarm bits |

## Verification
On every cycle, the in-RTL assertions check the following:
- once set, an alarm bit holds until acknowledged;
- no bit appears without a violation;
- an acknowledge clears every bit not newly violated;
- limit read-back never shows set low bits;
- a written high limit lands in its slot;
- out-of-range channel indices leave the bitmask untouched.

Only the bench scenarios show the strict-inequality boundaries. This covers samples exactly at and one count beyond the quantised limits, the default limits after reset, and the old-limit comparison when a write and a sample of one channel collide. They also cover the set-wins-over-clear case.

// File: rtl/vlm_pkg.sv
package vlm_pkg;

  // Kind of register access decoded from the address
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_LOW   = 2'd1,
    ACC_HIGH  = 2'd2,
    ACC_CLEAR = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/vlm_limit_regs.sv
module vlm_limit_regs
  import vlm_pkg::*;
#(
  parameter int NUM_CH    = 9,
  parameter int DATA_W    = 8,
  parameter int DROP_BITS = 2,
  parameter int CH_W      = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  acc_kind_e                      wr_kind,
  input  logic [CH_W-1:0]                wr_ch,
  input  logic [DATA_W-DROP_BITS-1:0]    wr_keep,
  output logic [NUM_CH-1:0][DATA_W-1:0]  lo_full,
  output logic [NUM_CH-1:0][DATA_W-1:0]  hi_full
);

  localparam int KEEP_W = DATA_W - DROP_BITS;

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    logic [KEEP_W-1:0] lo_q, lo_d, hi_q, hi_d;
    logic              sel;

    assign sel = wr_en && (wr_ch == CH_W'(gi));

    always_comb begin
      lo_d = lo_q;
      hi_d = hi_q;
      if (sel && (wr_kind == ACC_LOW))  lo_d = wr_keep;
      if (sel && (wr_kind == ACC_HIGH)) hi_d = wr_keep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '1;
      end else if (sel) begin
        lo_q <= lo_d;
        hi_q <= hi_d;
      end
    end

    assign lo_full[gi] = {lo_q, {DROP_BITS{1'b0}}};
    assign hi_full[gi] = {hi_q, {DROP_BITS{1'b0}}};

    AST_HIGH_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_kind == ACC_HIGH && wr_ch == CH_W'(gi)) |=> (hi_q == $past(wr_keep))); // R2
  end

endmodule

// File: rtl/vlm_compare.sv
module vlm_compare #(
  parameter int NUM_CH = 9,
  parameter int DATA_W = 8,
  parameter int CH_W   = 4
) (
  input  logic                          smp_vld,
  input  logic [CH_W-1:0]               smp_ch,
  input  logic [DATA_W-1:0]             smp_data,
  input  logic [NUM_CH-1:0][DATA_W-1:0] lo_full,
  input  logic [NUM_CH-1:0][DATA_W-1:0] hi_full,
  output logic [NUM_CH-1:0]             set_vec
);

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_cmp
    logic hit, below, above;
    assign hit   = smp_vld && (smp_ch == CH_W'(gi));
    assign below = smp_data < lo_full[gi];
    assign above = smp_data > hi_full[gi];
    assign set_vec[gi] = hit && (below || above);
  end

endmodule

// File: rtl/vlm_alarm_reg.sv
module vlm_alarm_reg #(
  parameter int NUM_CH = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [NUM_CH-1:0] set_vec,
  output logic [NUM_CH-1:0] alarm_q
);

  logic [NUM_CH-1:0] alarm_d;
  logic              upd;

  assign upd = clr || (|set_vec);

  always_comb begin
    alarm_d = clr ? '0 : alarm_q;
    alarm_d = alarm_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   alarm_q <= '0;
    else if (upd) alarm_q <= alarm_d;
  end

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chk
    AST_SET_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[gi] |=> alarm_q[gi]); // R6
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_q[gi] && !clr) |=> alarm_q[gi]); // R7
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set_vec[gi]) |=> !alarm_q[gi]); // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_q[gi] && !set_vec[gi]) |=> !alarm_q[gi]); // R6
  end

endmodule

// File: rtl/volt_limit_mon.sv
module volt_limit_mon
  import vlm_pkg::*;
#(
  parameter int NUM_CH    = 9,
  parameter int DATA_W    = 8,
  parameter int DROP_BITS = 2,
  parameter int CH_W      = $clog2(NUM_CH),
  parameter int ADDR_W    = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [CH_W-1:0]   smp_ch,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] alarm_mask
);

  localparam int KEEP_W = DATA_W - DROP_BITS;

  acc_kind_e                     kind;
  logic [CH_W-1:0]               addr_ch;
  logic [NUM_CH-1:0][DATA_W-1:0] lo_full, hi_full;
  logic [NUM_CH-1:0]             set_vec;
  logic                          wr_en, clr;
  logic                          unused_lsb;

  assign addr_ch    = reg_addr[CH_W-1:0];
  assign unused_lsb = ^reg_wdata[DROP_BITS-1:0];

  // Address decode: all-ones is the acknowledge address, MSB picks bank
  always_comb begin
    if (reg_addr == '1)                  kind = ACC_CLEAR;
    else if (32'(addr_ch) >= NUM_CH)     kind = ACC_NONE;
    else if (reg_addr[ADDR_W-1])         kind = ACC_HIGH;
    else                                 kind = ACC_LOW;
  end

  assign wr_en = reg_we && ((kind == ACC_LOW) || (kind == ACC_HIGH));
  assign clr   = reg_re && (kind == ACC_CLEAR);

  vlm_limit_regs #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .DROP_BITS(DROP_BITS), .CH_W(CH_W)
  ) u_limits (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_kind (kind),
    .wr_ch   (addr_ch),
    .wr_keep (reg_wdata[DATA_W-1:DROP_BITS]),
    .lo_full (lo_full),
    .hi_full (hi_full)
  );

  vlm_compare #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)
  ) u_cmp (
    .smp_vld  (smp_vld),
    .smp_ch   (smp_ch),
    .smp_data (smp_data),
    .lo_full  (lo_full),
    .hi_full  (hi_full),
    .set_vec  (set_vec)
  );

  vlm_alarm_reg #(
    .NUM_CH(NUM_CH)
  ) u_alarm (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .set_vec (set_vec),
    .alarm_q (alarm_mask)
  );

  // Read-back mux
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_ch == CH_W'(i)) begin
        if (kind == ACC_LOW)  reg_rdata = lo_full[i];
        if (kind == ACC_HIGH) reg_rdata = hi_full[i];
      end
    end
  end

  AST_LIMIT_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DROP_BITS-1:0] == '0); // R3
  AST_OOR_SAMPLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && (32'(smp_ch) >= NUM_CH) && !clr) |=> $stable(alarm_mask)); // R9
  AST_KEEP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (KEEP_W > 0) |-> (reg_rdata <= {{KEEP_W{1'b1}}, {DROP_BITS{1'b0}}})); // R3

endmodule

// File: tb/volt_limit_mon_tb.sv
module volt_limit_mon_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_vld, reg_we, reg_re;
  logic [3:0] smp_ch;
  logic [7:0] smp_data, reg_wdata, reg_rdata;
  logic [4:0] reg_addr;
  logic [8:0] alarm_mask;

  int checks = 0;
  int fails  = 0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  logic [7:0] m_lo[9];
  logic [7:0] m_hi[9];
  logic [8:0] m_al;

  always #2 clk = ~clk;  // 250 MHz

  volt_limit_mon dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_ch(smp_ch),
    .smp_data(smp_data), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alarm_mask(alarm_mask)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Monitor: pops expected alarm masks and compares
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [8:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (alarm_mask !== e) begin
        fails++;
        $display("FAIL %s alarm_mask actual=%h expected=%h", t, alarm_mask, e);
      end
    end
  end

  // Driver: one cycle of stimulus, reference result pushed to the queue
  task automatic step(input logic vld, input int ch, input logic [7:0] d,
                      input logic we, input logic [4:0] a, input logic [7:0] wd,
                      input logic re, input string tag);
    logic [8:0] set_v, nxt;
    @(negedge clk);
    smp_vld = vld; smp_ch = 4'(ch); smp_data = d;
    reg_we = we; reg_addr = a; reg_wdata = wd; reg_re = re;
    set_v = '0;
    if (vld && ch < 9 && (d < m_lo[ch] || d > m_hi[ch])) set_v[ch] = 1'b1;
    nxt = ((re && a == 5'd31) ? 9'd0 : m_al) | set_v;
    if (we && a != 5'd31 && a[3:0] < 4'd9) begin
      if (a[4]) m_hi[a[3:0]] = wd & 8'hFC;
      else      m_lo[a[3:0]] = wd & 8'hFC;
    end
    m_al = nxt;
    @(posedge clk);
    #1;
    exp_q.push_back(nxt);
    tag_q.push_back(tag);
    smp_vld = 1'b0; reg_we = 1'b0; reg_re = 1'b0;
  endtask

  task automatic smp(input int ch, input logic [7:0] d, input string tag);
    step(1'b1, ch, d, 1'b0, 5'd0, 8'h00, 1'b0, tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] wd, input string tag);
    step(1'b0, 0, 8'h00, 1'b1, a, wd, 1'b0, tag);
  endtask

  task automatic ack(input string tag);
    step(1'b0, 0, 8'h00, 1'b0, 5'd31, 8'h00, 1'b1, tag);
  endtask

  task automatic rd_check(input logic [4:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== e) begin
      fails++;
      $display("FAIL %s rdata@%0d actual=%h expected=%h", tag, a, reg_rdata, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    smp_vld = 1'b0; smp_ch = '0; smp_data = '0;
    reg_we = 1'b0; reg_re = 1'b0; reg_addr = '0; reg_wdata = '0;
    for (int i = 0; i < 9; i++) begin m_lo[i] = 8'h00; m_hi[i] = 8'hFC; end
    m_al = '0;
    repeat (3) @(posedge clk);
    // R1: values while in reset
    rd_check(5'd0, 8'h00, "R1 low default");
    rd_check(5'd24, 8'hFC, "R1 high default");
    checks++;
    if (alarm_mask !== 9'd0) begin
      fails++;
      $display("FAIL R1 alarm_mask actual=%h expected=000", alarm_mask);
    end
    @(negedge clk); rst_n = 1'b1;
    rd_check(5'd8, 8'h00, "R1 low default after release");
    rd_check(5'd16, 8'hFC, "R1 high default after release");

    // R2 / R3: programming and read-back
    wr(5'd1, 8'h41, "R2 write low ch1");
    wr(5'd17, 8'h83, "R2 write high ch1");
    rd_check(5'd1, 8'h40, "R3 low ch1 lsb dropped");
    rd_check(5'd17, 8'h80, "R3 high ch1 lsb dropped");
    wr(5'd10, 8'hAA, "R2 write unmapped");
    rd_check(5'd10, 8'h00, "R2 unmapped reads zero");
    rd_check(5'd26, 8'h00, "R2 unmapped high bank");

    // R4 / R5: boundaries on ch1 (low 0x40, high 0x80)
    smp(1, 8'h40, "R4 equal low no alarm");
    smp(1, 8'h80, "R5 equal high no alarm");
    smp(1, 8'h41, "R3 value 0x41 is above quantised low");
    smp(1, 8'h3F, "R4 below low sets bit1");
    ack("R8 ack clears");
    smp(1, 8'h81, "R5 above high sets bit1");
    ack("R8 ack clears again");

    // R5 / R6 with default limits
    smp(0, 8'h00, "R4 zero at default low no alarm");
    smp(0, 8'hFC, "R5 equal default high no alarm");
    smp(0, 8'hFD, "R5 above default high bit0");
    smp(8, 8'hFF, "R6 ch8 maps to bit8");

    // R7: sticky
    smp(8, 8'h10, "R7 in-range does not clear bit8");
    smp(0, 8'h20, "R7 in-range does not clear bit0");

    // R8: clear with simultaneous violation
    step(1'b1, 0, 8'hFF, 1'b0, 5'd31, 8'h00, 1'b1, "R8 set wins over clear");
    ack("R8 plain clear");

    // R9: out-of-range channel index
    smp(9, 8'hFF, "R9 channel 9 ignored");
    smp(15, 8'hFF, "R9 channel 15 ignored");

    // R10: write and sample of same channel in one cycle
    step(1'b1, 2, 8'h50, 1'b1, 5'd2, 8'h80, 1'b0, "R10 old low used");
    rd_check(5'd2, 8'h80, "R2 low ch2 updated");
    smp(2, 8'h50, "R10 new low now applies bit2");
    step(1'b1, 2, 8'h90, 1'b1, 5'd18, 8'h40, 1'b1, "R10 old high used with clear");
    smp(2, 8'h90, "R10 new high now applies");

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule